// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block fronts a small single-ported word memory and carries out indivisible read-modify-write operations for four requesters. Each requester presents an opcode, a word address and a write value. A fixed-priority selector picks one pending request at a time. The selected operation reads the word in one cycle and, if needed, writes it back in the next. No other requester gets the memory port between the read and the write.

The supported operations are plain load and store, atomic swap, test-and-set (the write happens only when the word reads zero), fetch-and-increment, and a linked-load / conditional-store pair. A reservation monitor keeps one reservation per requester. Any store to a reserved word by another requester cancels that reservation. A later conditional store from the holder then fails and leaves memory untouched. For lock variables, a word holding 0 is free and a word holding 1 is taken. A swap or test-and-set that returns 0 means the lock was acquired.

Top module: `amo_unit`

## Requirements
- R1: Reset clears every memory word to zero and drops every reservation. While reset is held and just after it, `rsp_valid` is low and no request is accepted.
- R2: Opcode 0 (load) returns the word at the address and leaves it unchanged. Opcode 1 (store) writes the supplied value and returns 0.
- R3: Opcode 2 (swap) writes the supplied value and returns the word's previous contents.
- R4: Opcode 3 (test-and-set) returns the previous contents. It writes the supplied value only when those contents are zero; otherwise memory is unchanged.
- R5: Opcode 4 (fetch-and-increment) returns the previous contents and stores that value plus one, wrapping modulo 2^32.
- R6: Opcode 5 (linked load) returns the word and gives its requester a reservation on that address. A requester holds at most one reservation, and a new linked load replaces the old one.
- R7: Opcode 6 (conditional store) writes the value and returns 1 only if the requester holds a valid reservation on that same address. Otherwise it returns 0 and writes nothing. The response is always 0 or 1.
- R8: Any memory write by one requester (store, swap, passing test-and-set, increment, successful conditional store) to an address cancels other requesters' reservations on that address. Writes to other addresses leave those reservations intact.
- R9: A conditional store always consumes its requester's reservation, whether or not it succeeds.
- R10: The response for an accepted request appears exactly two cycles after acceptance and carries that requester's index. In the cycle after an acceptance, no request is accepted.
- R11: `req_ready` is one-hot or zero. It is only set for a requester whose `req_valid` is high, and it always picks the lowest-numbered pending requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Per-requester request pending |
| req_op | input | NREQ*3 | Opcodes, requester i in bits [3i+2:3i] |
| req_addr | input | NREQ*AW | Word addresses, requester i in slice i |
| req_wdata | input | NREQ*DW | Write values, requester i in slice i |
| req_ready | output | NREQ | Request accepted this cycle (one-hot) |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | $clog2(NREQ) | Requester the response belongs to |
| rsp_data | output | DW | Old value, success flag, or 0 for store |

## Verification
The bound checker watches the selector on every cycle: the grant is one-hot, goes only to a pending requester, and goes to the lowest-numbered one. It also checks the lock window after each acceptance, the two-cycle response latency with the correct requester index, and that a conditional store only ever answers 0 or 1. Data results cannot be checked that way. The values swap, test-and-set and increment return, and the way reservations are replaced, consumed or cancelled by other requesters' writes, depend on history. Only the bench's operation sequences, followed by read-back loads, can show them.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int unsigned AMO_DW = 32;
    localparam int unsigned AMO_OPW = 3;

    typedef enum logic [AMO_OPW-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_SWAP  = 3'd2,
        OP_TAS   = 3'd3,
        OP_FINC  = 3'd4,
        OP_LL    = 3'd5,
        OP_SC    = 3'd6
    } amo_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } amo_state_e;

    typedef struct packed {
        logic              wr;
        logic [AMO_DW-1:0] wval;
        logic [AMO_DW-1:0] rsp;
    } amo_result_t;

    // Second half of every operation: given the word read in the first cycle,
    // decide the write-back and the response value.
    function automatic amo_result_t amo_eval(amo_op_e op, logic [AMO_DW-1:0] old,
                                             logic [AMO_DW-1:0] wd, logic sc_ok);
        amo_result_t r;
        r.wr   = 1'b0;
        r.wval = wd;
        r.rsp  = old;
        case (op)
            OP_STORE: begin
                r.wr  = 1'b1;
                r.rsp = '0;
            end
            OP_SWAP: r.wr = 1'b1;
            OP_TAS:  r.wr = (old == '0);
            OP_FINC: begin
                r.wr   = 1'b1;
                r.wval = old + AMO_DW'(1);
            end
            OP_SC: begin
                r.wr  = sc_ok;
                r.rsp = AMO_DW'(sc_ok);
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/amo_arb.sv
module amo_arb #(
    parameter int unsigned N   = 4,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          en,
    input  logic [N-1:0]  valid,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] gid
);
    logic [N:0] blocked;
    assign blocked[0] = ~en;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]     = valid[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | valid[i];
    end

    always_comb begin
        gid = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant[i]) gid = IW'(i);
        end
    end
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 4,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ren,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) words[waddr] <= wdata;
            if (ren) rdata <= words[raddr];
        end
    end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
    parameter int unsigned N   = 4,
    parameter int unsigned AW  = 4,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev,
    input  logic [IW-1:0] id,
    input  logic [AW-1:0] addr,
    input  logic          is_ll,
    input  logic          is_sc,
    input  logic          wr,
    output logic          sc_ok
);
    logic [N-1:0]  res_v;
    logic [AW-1:0] res_a [N];

    assign sc_ok = res_v[id] && (res_a[id] == addr);

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                res_v[i] <= 1'b0;
                res_a[i] <= '0;
            end else if (ev) begin
                if (id == IW'(i)) begin
                    if (is_ll) begin
                        res_v[i] <= 1'b1;
                        res_a[i] <= addr;
                    end else if (is_sc) begin
                        res_v[i] <= 1'b0;   // R9: consumed either way
                    end
                end else if (wr && res_a[i] == addr) begin
                    res_v[i] <= 1'b0;       // R8: foreign write cancels
                end
            end
        end
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int unsigned NREQ = 4,
    parameter int unsigned DW   = AMO_DW,
    parameter int unsigned AW   = 4,
    localparam int unsigned IDW = $clog2(NREQ),
    localparam int unsigned OPW = AMO_OPW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NREQ-1:0]     req_valid,
    input  logic [NREQ*OPW-1:0] req_op,
    input  logic [NREQ*AW-1:0]  req_addr,
    input  logic [NREQ*DW-1:0]  req_wdata,
    output logic [NREQ-1:0]     req_ready,
    output logic                rsp_valid,
    output logic [IDW-1:0]      rsp_id,
    output logic [DW-1:0]       rsp_data
);
    amo_state_e    state;
    logic [IDW-1:0] gid, cur_id;
    amo_op_e       cur_op;
    logic [AW-1:0] cur_addr, sel_addr;
    logic [DW-1:0] cur_wd, sel_wd, mem_rdata;
    logic [OPW-1:0] sel_op;
    logic          accept, exec, sc_ok;
    amo_result_t   res;

    amo_arb #(.N(NREQ)) u_arb (
        .en    (state == ST_IDLE && !rst),
        .valid (req_valid),
        .grant (req_ready),
        .gid   (gid)
    );

    assign accept = |req_ready;
    assign exec   = (state == ST_EXEC);

    always_comb begin
        sel_op   = req_op[gid*OPW +: OPW];
        sel_addr = req_addr[gid*AW +: AW];
        sel_wd   = req_wdata[gid*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_id   <= '0;
            cur_op   <= OP_LOAD;
            cur_addr <= '0;
            cur_wd   <= '0;
        end else if (accept) begin
            state    <= ST_EXEC;
            cur_id   <= gid;
            cur_op   <= amo_op_e'(sel_op);
            cur_addr <= sel_addr;
            cur_wd   <= sel_wd;
        end else if (exec) begin
            state    <= ST_IDLE;
        end
    end

    amo_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .ren   (accept),
        .raddr (sel_addr),
        .rdata (mem_rdata),
        .we    (exec && res.wr),
        .waddr (cur_addr),
        .wdata (res.wval)
    );

    amo_resv #(.N(NREQ), .AW(AW)) u_resv (
        .clk   (clk),
        .rst   (rst),
        .ev    (exec),
        .id    (cur_id),
        .addr  (cur_addr),
        .is_ll (cur_op == OP_LL),
        .is_sc (cur_op == OP_SC),
        .wr    (res.wr),
        .sc_ok (sc_ok)
    );

    assign res = amo_eval(cur_op, mem_rdata, cur_wd, sc_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= exec;
            if (exec) begin
                rsp_id   <= cur_id;
                rsp_data <= res.rsp;
            end
        end
    end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
    import amo_pkg::*;
#(
    parameter int unsigned NREQ = 4,
    parameter int unsigned DW   = 32,
    localparam int unsigned IDW = $clog2(NREQ),
    localparam int unsigned OPW = AMO_OPW
) (
    input logic                clk,
    input logic                rst,
    input logic [NREQ-1:0]     req_valid,
    input logic [NREQ*OPW-1:0] req_op,
    input logic [NREQ-1:0]     req_ready,
    input logic                rsp_valid,
    input logic [IDW-1:0]      rsp_id,
    input logic [DW-1:0]       rsp_data
);
    localparam logic [NREQ-1:0] ONE = NREQ'(1);

    logic [IDW-1:0] id_q;
    logic [OPW-1:0] op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q <= '0;
            op_q <= '0;
        end else begin
            for (int i = 0; i < NREQ; i++) begin
                if (req_ready[i]) begin
                    id_q <= IDW'(i);
                    op_q <= req_op[i*OPW +: OPW];
                end
            end
        end
    end

    assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));
    assert_grant_pending_R11: assert property (@(posedge clk) disable iff (rst)
        (req_ready & ~req_valid) == '0);
    assert_grant_lowest_R11: assert property (@(posedge clk) disable iff (rst)
        (|req_ready) |-> ((req_valid & (req_ready - ONE)) == '0));
    assert_port_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (|req_ready) |=> (req_ready == '0));
    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (|req_ready) |=> ##1 rsp_valid);
    assert_rsp_cause_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(|req_ready, 2));
    assert_rsp_owner_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_id == id_q));
    assert_sc_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && op_q == OP_SC) |-> (rsp_data <= DW'(1)));
endmodule

bind amo_unit amo_unit_chk #(.NREQ(NREQ), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_id    (rsp_id),
    .rsp_data  (rsp_data)
);

// File: tb/sim_amo_unit.sv
module sim_amo_unit;
    localparam int unsigned NREQ = 4;
    localparam int unsigned DW   = 32;
    localparam int unsigned AW   = 4;
    localparam int unsigned OPW  = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NREQ-1:0]     req_valid = '0;
    logic [NREQ*OPW-1:0] req_op = '0;
    logic [NREQ*AW-1:0]  req_addr = '0;
    logic [NREQ*DW-1:0]  req_wdata = '0;
    logic [NREQ-1:0]     req_ready;
    logic                rsp_valid;
    logic [1:0]          rsp_id;
    logic [DW-1:0]       rsp_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] got;

    always #4 clk = ~clk;   // 125 MHz

    amo_unit #(.NREQ(NREQ), .DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request through the normal handshake; checks latency (R10).
    task automatic run(input int id, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd);
        @(negedge clk);
        req_op[id*OPW +: OPW]  = op;
        req_addr[id*AW +: AW]  = a;
        req_wdata[id*DW +: DW] = wd;
        req_valid[id]          = 1'b1;
        #1;
        while (!req_ready[id]) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid[id] = 1'b0;
        check(rsp_valid == 1'b0, "R10 no response one cycle after accept",
              DW'(rsp_valid), 0);
        @(negedge clk);
        check(rsp_valid == 1'b1 && rsp_id == 2'(id), "R10 response two cycles after accept",
              {rsp_valid, 29'd0, rsp_id}, {1'b1, 29'd0, 2'(id)});
        got = rsp_data;
    endtask

    // {id[2], op[3], addr[4], wdata[32], expected[32], requirement[4]}
    localparam int NV = 42;
    localparam logic [76:0] VEC [NV] = '{
        {2'd0, 3'd1, 4'd3,  32'h11,        32'h0,        4'd2},  // R2 store
        {2'd1, 3'd0, 4'd3,  32'h0,         32'h11,       4'd2},  // R2 load
        {2'd0, 3'd2, 4'd3,  32'hAA,        32'h11,       4'd3},  // R3 swap
        {2'd2, 3'd0, 4'd3,  32'h0,         32'hAA,       4'd3},
        {2'd1, 3'd3, 4'd4,  32'h1,         32'h0,        4'd4},  // R4 acquire
        {2'd2, 3'd3, 4'd4,  32'h5,         32'h1,        4'd4},  // R4 held
        {2'd3, 3'd0, 4'd4,  32'h0,         32'h1,        4'd4},  // R4 unchanged
        {2'd3, 3'd2, 4'd4,  32'h0,         32'h1,        4'd3},  // release
        {2'd0, 3'd3, 4'd4,  32'h7,         32'h0,        4'd4},
        {2'd0, 3'd1, 4'd6,  32'hFFFFFFFF,  32'h0,        4'd2},
        {2'd1, 3'd4, 4'd6,  32'h0,         32'hFFFFFFFF, 4'd5},  // R5 wrap
        {2'd1, 3'd0, 4'd6,  32'h0,         32'h0,        4'd5},
        {2'd2, 3'd4, 4'd6,  32'h0,         32'h0,        4'd5},
        {2'd2, 3'd5, 4'd6,  32'h0,         32'h1,        4'd6},  // R6
        {2'd2, 3'd6, 4'd6,  32'h55,        32'h1,        4'd7},  // R7 success
        {2'd2, 3'd0, 4'd6,  32'h0,         32'h55,       4'd7},
        {2'd3, 3'd6, 4'd6,  32'h66,        32'h0,        4'd7},  // R7 none held
        {2'd3, 3'd0, 4'd6,  32'h0,         32'h55,       4'd7},
        {2'd3, 3'd5, 4'd7,  32'h0,         32'h0,        4'd6},
        {2'd0, 3'd1, 4'd8,  32'h9,         32'h0,        4'd8},  // R8 other address
        {2'd3, 3'd6, 4'd7,  32'h77,        32'h1,        4'd8},
        {2'd3, 3'd6, 4'd7,  32'h78,        32'h0,        4'd9},  // R9 consumed
        {2'd3, 3'd0, 4'd7,  32'h0,         32'h77,       4'd9},
        {2'd0, 3'd5, 4'd7,  32'h0,         32'h77,       4'd6},
        {2'd1, 3'd5, 4'd7,  32'h0,         32'h77,       4'd6},
        {2'd1, 3'd6, 4'd7,  32'h10,        32'h1,        4'd7},
        {2'd0, 3'd6, 4'd7,  32'h20,        32'h0,        4'd8},  // R8 killed by SC
        {2'd0, 3'd0, 4'd7,  32'h0,         32'h10,       4'd8},
        {2'd2, 3'd5, 4'd9,  32'h0,         32'h0,        4'd6},
        {2'd2, 3'd5, 4'd10, 32'h0,         32'h0,        4'd6},  // R6 replace
        {2'd2, 3'd6, 4'd9,  32'h3,         32'h0,        4'd6},  // R6 old address gone
        {2'd2, 3'd0, 4'd9,  32'h0,         32'h0,        4'd7},
        {2'd0, 3'd5, 4'd11, 32'h0,         32'h0,        4'd6},
        {2'd1, 3'd4, 4'd11, 32'h0,         32'h0,        4'd5},
        {2'd0, 3'd6, 4'd11, 32'h5,         32'h0,        4'd8},  // R8 killed by increment
        {2'd0, 3'd0, 4'd11, 32'h0,         32'h1,        4'd8},
        {2'd1, 3'd5, 4'd12, 32'h0,         32'h0,        4'd6},
        {2'd2, 3'd3, 4'd12, 32'h1,         32'h0,        4'd4},
        {2'd1, 3'd6, 4'd12, 32'h9,         32'h0,        4'd8},  // R8 killed by TAS
        {2'd3, 3'd5, 4'd13, 32'h0,         32'h0,        4'd6},
        {2'd3, 3'd1, 4'd13, 32'h4,         32'h0,        4'd2},  // own store
        {2'd3, 3'd6, 4'd13, 32'h8,         32'h1,        4'd7}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        req_valid = 4'b0001;   // held during reset: must not be taken (R1)
        #1;
        check(req_ready == '0 && rsp_valid == 1'b0, "R1 idle under reset",
              {27'd0, req_ready, rsp_valid}, 0);
        @(negedge clk);
        req_valid = '0;
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 no response after reset", DW'(rsp_valid), 0);

        run(0, 3'd0, 4'd5, 0);
        check(got == 0, "R1 memory cleared", got, 0);

        for (int i = 0; i < NV; i++) begin
            run(int'(VEC[i][76:75]), VEC[i][74:72], VEC[i][71:68], VEC[i][67:36]);
            check(got == VEC[i][35:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i),
                  got, VEC[i][35:4]);
        end

        // R11: two requesters at once, lowest first, port locked meanwhile.
        @(negedge clk);
        req_op[1*OPW +: OPW] = 3'd0; req_addr[1*AW +: AW] = 4'd3;
        req_op[2*OPW +: OPW] = 3'd0; req_addr[2*AW +: AW] = 4'd6;
        req_valid = 4'b0110;
        #1;
        check(req_ready == 4'b0010, "R11 lowest pending wins", DW'(req_ready), 32'h2);
        @(negedge clk);
        req_valid[1] = 1'b0;
        check(req_ready == 4'b0000, "R10 port locked", DW'(req_ready), 0);
        @(negedge clk);
        check(rsp_valid && rsp_id == 2'd1 && rsp_data == 32'hAA, "R11 first response",
              rsp_data, 32'hAA);
        check(req_ready == 4'b0100, "R11 next requester served", DW'(req_ready), 32'h4);
        @(negedge clk);
        req_valid[2] = 1'b0;
        @(negedge clk);
        check(rsp_valid && rsp_id == 2'd2 && rsp_data == 32'h55, "R11 second response",
              rsp_data, 32'h55);

        // R1: reset drops reservations and clears memory.
        run(0, 3'd5, 4'd2, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run(0, 3'd6, 4'd2, 32'h9);
        check(got == 0, "R1 reservation dropped by reset", got, 0);
        run(1, 3'd0, 4'd3, 0);
        check(got == 0, "R1 memory cleared by reset", got, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule